// File: doc/BRIEF.md
# Smart Card Serial Clock Stop/Start Controller

This block drives the serial clock pin of a smart card interface. The clock is the system clock divided by an even ratio, so its duty cycle is exactly 50 percent. Software controls it through a single control register. One bit enables the clock and one bit selects the level at which the pin rests while the clock is stopped. The same register also holds the transmit and receive enables. Because all four fields sit in one word, one write can both shut down the data paths and choose the rest level.

When software clears the clock enable, the stop is not immediate. The controller lets the serial period in progress finish. It then runs one more complete period with normal duty. Only after that does it drive the pin to the selected rest level and raise a stopped flag. A standby request is acknowledged only while that flag is high. Setting the enable again starts a fresh period that begins at the rest level, so no short pulse appears on the pin.

Top module: `sc_clkstop`

## Requirements
- R1: After reset, `sck_out` is 0, `clk_stopped` is 1, and `tx_en`, `rx_en` and `stby_ack` are 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the control register at that clock edge. The fields are: bit 0 clock enable, bit 1 rest level, bit 2 transmit enable, bit 3 receive enable. `tx_en` and `rx_en` show bits 2 and 3 from the next cycle on, so a single write can clear both data enables and set the rest level together.
- R3: While running, each half of a serial period lasts H system cycles, where H is `div_half`. A value of 0 is treated as 1. The serial period is therefore 2·H cycles with equal high and low times.
- R4: If the clock enable is 1 while stopped, `clk_stopped` falls at the next edge. The pin then holds the rest level for H cycles before its first transition.
- R5: A period ends when the pin returns to the level it started from. If the enable is 0 at the end of a period, the controller runs exactly one more full period with normal duty before stopping.
- R6: At the end of that extra period, `sck_out` takes the rest level and `clk_stopped` rises at the same edge. While stopped, `sck_out` does not change.
- R7: The rest level is captured when the final period begins. Writing the rest-level bit while the clock runs does not change the pin until that point.
- R8: A new `div_half` value is taken up only at a period boundary. A change in the middle of a period never shortens or stretches the half already under way.
- R9: `stby_ack` equals `stby_req` AND `clk_stopped`.
- R10: If the enable is cleared and set again before the current period ends, the clock does not stop and `clk_stopped` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control word {rx_en, tx_en, rest level, clock enable} |
| div_half | input | DIV_W | Half-period length in system cycles (0 acts as 1) |
| stby_req | input | 1 | Standby request from power control |
| sck_out | output | 1 | Serial clock to the card |
| clk_stopped | output | 1 | High while the clock is parked |
| tx_en | output | 1 | Transmit enable from the control register |
| rx_en | output | 1 | Receive enable from the control register |
| stby_ack | output | 1 | Standby accepted |

## Verification
The bench builds the block with `DIV_W` = 4. This keeps half-periods between 1 and 15 cycles, so the smallest ratio (a `div_half` of 0, acting as 1) and ratio changes in the middle of a period both show up within a few dozen cycles. With such short periods, the bench can also land a stop request at a chosen point of a period. That makes it possible to exercise the full drain sequence with both rest levels, and the cancelled stop in which the enable drops and returns before the period ends.

// File: rtl/sc_clkstop_pkg.sv
package sc_clkstop_pkg;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic park_lvl;
    logic clk_en;
  } sc_ctrl_t;

  typedef enum logic [1:0] {
    ST_PARKED = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2
  } sc_state_t;

endpackage

// File: rtl/sc_ctrl_reg.sv
module sc_ctrl_reg
  import sc_clkstop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output sc_ctrl_t          ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl <= sc_ctrl_t'(wr_data);
    end
  end

endmodule

// File: rtl/sc_div_timer.sv
module sc_div_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] div_half,
  output logic             mid_evt,
  output logic             period_evt
);

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_cur;
  logic             second_half;
  logic             half_end;

  assign half_end   = active && (cnt == half_cur - DIV_W'(1));
  assign mid_evt    = half_end && !second_half;
  assign period_evt = half_end && second_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      second_half <= 1'b0;
      half_cur    <= DIV_W'(1);
    end else if (restart) begin
      cnt         <= '0;
      second_half <= 1'b0;
      half_cur    <= eff_half(div_half);
    end else if (active) begin
      if (half_end) begin
        cnt <= '0;
        if (second_half) begin
          second_half <= 1'b0;
          half_cur    <= eff_half(div_half);
        end else begin
          second_half <= 1'b1;
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/sc_stop_fsm.sv
module sc_stop_fsm
  import sc_clkstop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clk_en,
  input  logic      park_lvl,
  input  logic      mid_evt,
  input  logic      period_evt,
  output logic      restart,
  output logic      active,
  output logic      park_cap,
  output logic      sck,
  output sc_state_t state
);

  logic start_lvl;

  assign restart = (state == ST_PARKED) && clk_en;
  assign active  = (state != ST_PARKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PARKED;
      park_cap  <= 1'b0;
      start_lvl <= 1'b0;
      sck       <= 1'b0;
    end else begin
      unique case (state)
        ST_PARKED: begin
          if (clk_en) begin
            state     <= ST_RUN;
            start_lvl <= park_cap;
            sck       <= park_cap;
          end
        end
        ST_RUN: begin
          if (mid_evt) begin
            sck <= ~start_lvl;
          end else if (period_evt) begin
            sck <= start_lvl;
            if (!clk_en) begin
              state    <= ST_DRAIN;
              park_cap <= park_lvl;
            end
          end
        end
        ST_DRAIN: begin
          if (mid_evt) begin
            sck <= ~start_lvl;
          end else if (period_evt) begin
            state <= ST_PARKED;
            sck   <= park_cap;
          end
        end
        default: state <= ST_PARKED;
      endcase
    end
  end

endmodule

// File: rtl/sc_clkstop.sv
module sc_clkstop
  import sc_clkstop_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [sc_clkstop_pkg::CTRL_W-1:0] wr_data,
  input  logic [DIV_W-1:0]             div_half,
  input  logic                         stby_req,
  output logic                         sck_out,
  output logic                         clk_stopped,
  output logic                         tx_en,
  output logic                         rx_en,
  output logic                         stby_ack
);

  sc_ctrl_t  ctrl;
  sc_state_t state;
  logic      restart;
  logic      active;
  logic      mid_evt;
  logic      period_evt;
  logic      park_cap;

  sc_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  sc_div_timer #(.DIV_W(DIV_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .active     (active),
    .div_half   (div_half),
    .mid_evt    (mid_evt),
    .period_evt (period_evt)
  );

  sc_stop_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (ctrl.clk_en),
    .park_lvl   (ctrl.park_lvl),
    .mid_evt    (mid_evt),
    .period_evt (period_evt),
    .restart    (restart),
    .active     (active),
    .park_cap   (park_cap),
    .sck        (sck_out),
    .state      (state)
  );

  assign clk_stopped = (state == ST_PARKED);
  assign tx_en       = ctrl.tx_en;
  assign rx_en       = ctrl.rx_en;
  assign stby_ack    = stby_req && clk_stopped;

endmodule

// File: rtl/sc_clkstop_chk.sv
module sc_clkstop_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_out,
  input logic clk_stopped,
  input logic stby_req,
  input logic stby_ack,
  input logic clk_en,
  input logic park_cap,
  input logic mid_evt,
  input logic period_evt
);

  AST_PARKED_PIN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stopped && $past(clk_stopped)) |-> $stable(sck_out)) else $error("parked pin moved"); // R6

  AST_STOP_NEEDS_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stopped) |-> ($past(period_evt) && !$past(clk_en))) else $error("stop without request"); // R5

  AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_stopped) |-> (sck_out == park_cap)) else $error("wrong rest level"); // R7

  AST_EDGE_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clk_stopped) && (sck_out != $past(sck_out))) |-> $past(mid_evt || period_evt)) else $error("runt edge"); // R3

  AST_ACK_ONLY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    stby_ack |-> (clk_stopped && stby_req)) else $error("early standby ack"); // R9

endmodule

bind sc_clkstop sc_clkstop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sck_out     (sck_out),
  .clk_stopped (clk_stopped),
  .stby_req    (stby_req),
  .stby_ack    (stby_ack),
  .clk_en      (ctrl.clk_en),
  .park_cap    (park_cap),
  .mid_evt     (mid_evt),
  .period_evt  (period_evt)
);

// File: tb/sc_clkstop_test.sv
module sc_clkstop_test;

  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_data = '0;
  logic [DW-1:0] div_half = '0;
  logic          stby_req = 1'b0;
  logic          sck_out, clk_stopped, tx_en, rx_en, stby_ack;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sc_clkstop #(.DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_half(div_half), .stby_req(stby_req), .sck_out(sck_out),
    .clk_stopped(clk_stopped), .tx_en(tx_en), .rx_en(rx_en), .stby_ack(stby_ack)
  );

  // behavioural reference: mode 0 parked, 1 running, 2 final period
  int m_mode, m_t, m_hv;
  bit m_start, m_cap, m_sck, m_ce, m_park, m_tx, m_rx;

  function automatic int half_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_hv = 1; m_start = 0; m_cap = 0; m_sck = 0;
      m_ce = 0; m_park = 0; m_tx = 0; m_rx = 0;
    end else begin
      if (m_mode == 0) begin
        if (m_ce) begin
          m_mode = 1; m_t = 0; m_hv = half_of(int'(div_half));
          m_start = m_cap; m_sck = m_cap;
        end
      end else begin
        m_t++;
        if (m_t == 2 * m_hv) begin
          m_t = 0;
          m_hv = half_of(int'(div_half));
          if (m_mode == 2) begin
            m_mode = 0; m_sck = m_cap;
          end else begin
            if (!m_ce) begin m_mode = 2; m_cap = m_park; end
            m_sck = m_start;
          end
        end else begin
          m_sck = m_start ^ (m_t >= m_hv);
        end
      end
      if (wr_en) {m_rx, m_tx, m_park, m_ce} = wr_data;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "sck_out", int'(sck_out), int'(m_sck));
      check(cur_req, "clk_stopped", int'(clk_stopped), int'(m_mode == 0));
      check("R2", "tx_en", int'(tx_en), int'(m_tx));
      check("R2", "rx_en", int'(rx_en), int'(m_rx));
      check("R9", "stby_ack", int'(stby_ack), int'(stby_req && m_mode == 0));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic write(input logic [3:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic wait_parked(input string req);
    int k = 0;
    while (!clk_stopped && k < 200) begin step(1); k++; end
    check(req, "reached parked state", int'(clk_stopped), 1);
  endtask

  initial begin
    step(3);
    @(negedge clk);
    cur_req = "R1";
    check("R1", "reset sck", int'(sck_out), 0);
    check("R1", "reset stopped", int'(clk_stopped), 1);
    check("R1", "reset tx/rx", int'(tx_en | rx_en), 0);
    rst_n = 1'b1;
    step(2);

    cur_req = "R2";
    write(4'b1100);
    @(negedge clk);
    check("R2", "tx_en after write", int'(tx_en), 1);
    check("R2", "rx_en after write", int'(rx_en), 1);

    cur_req = "R4";
    div_half = 4'd3;
    write(4'b1101);
    step(1);
    @(negedge clk);
    check("R4", "running after enable", int'(clk_stopped), 0);
    check("R4", "first half at rest level", int'(sck_out), 0);
    step(20);

    cur_req = "R7";
    write(4'b1111);        // rest level change while running
    step(15);
    cur_req = "R8";
    div_half = 4'd5;
    step(4);
    div_half = 4'd2;
    step(25);

    cur_req = "R5";
    stby_req = 1'b1;
    write(4'b0010);        // drop data enables, keep rest=1, stop
    @(negedge clk);
    check("R9", "no ack while running", int'(stby_ack), 0);
    wait_parked("R5");
    @(negedge clk);
    cur_req = "R6";
    check("R6", "parked at rest level 1", int'(sck_out), 1);
    check("R9", "ack when parked", int'(stby_ack), 1);
    step(10);
    stby_req = 1'b0;

    cur_req = "R3";
    div_half = 4'd0;
    write(4'b0011);
    step(30);
    div_half = 4'd15;
    step(70);

    cur_req = "R10";
    div_half = 4'd4;
    write(4'b0000);
    wait_parked("R10");
    write(4'b0001);
    step(2);
    write(4'b0000);
    write(4'b0001);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R10", "cancelled stop keeps running", int'(clk_stopped), 0);
      step(1);
    end

    cur_req = "R6";
    write(4'b0000);
    wait_parked("R6");
    @(negedge clk);
    check("R6", "parked at rest level 0", int'(sck_out), 0);
    step(12);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule